// File: doc/BRIEF.md
# Register-Mapped Single-Byte SPI Host

This block is an SPI host that a processor drives through a small byte-wide register port. One write to the data register starts one full-duplex 8-bit exchange. A busy flag in the status register shows when the exchange is running. Once that flag clears, a read of the data register returns the byte that came in on MISO. There is no queueing: software moves one byte per exchange. The serial clock comes from the base clock through a power-of-two divider. All four combinations of clock polarity and phase are available.

The chip-select lines are active low. Software chooses one line by writing its number to a select register. Writing 0xFF, or any value at or above the number of lines, deselects every line. Several processors can share the controller through an ownership flag in the status register. A status read returns the flag's old value and sets it, so a read that returns 0 means the caller now owns the controller. The owner frees it by writing a 1 to that bit. A read-only register reports a fixed code that names the base clock frequency.

Top module: `spi_byte_host`

## Requirements
- R1: After reset, the control register reads 0x0F and the select register reads 0xFF. Every `cs_no` line is high, status reads 0 (free and idle) and `sck_o` is low.
- R2: A read of address 0x03 returns {4'h0, CLK_CODE}. The codes are 0=62.5 MHz, 1=33.3 MHz, 2=125 MHz, 3=50 MHz and 4=100 MHz; the default is 4. Writes to this address change nothing.
- R3: The control register is at 0x04. Bits [3:0] hold the divider code n, bit 4 is CPHA and bit 5 is CPOL. Bits [5:0] read back as written and bits [7:6] read 0. While no exchange is running, `sck_o` equals CPOL.
- R4: A write to address 0x0C while idle starts an exchange. Status bit 1 (busy) then reads 1 for exactly 16·2^n clock cycles, counted from the cycle after the write. During that time `sck_o` makes 16 transitions and then returns to CPOL.
- R5: The written byte appears on `mosi_o` most significant bit first. Each bit is valid on its sampling edge: the leading edge (away from CPOL) when CPHA=0, and the trailing edge when CPHA=1.
- R6: MISO is captured on the leading edge of each bit when CPHA=0 and on the trailing edge when CPHA=1, most significant bit first. After busy clears, a read of 0x0C returns the captured byte.
- R7: A write to 0x0C while busy is high is ignored. The exchange in progress keeps its byte and its length.
- R8: Status bit 0 is the ownership flag. A status read (address 0x08) returns its current value and leaves it set. A status write with bit 0 = 1 clears it, and a status write with bit 0 = 0 leaves it unchanged.
- R9: The ownership flag changes only on a read strobe or a write strobe at address 0x08. Reads and writes of other addresses leave it unchanged.
- R10: The select register is at 0x10 and reads back as written. A value k below NUM_CS drives `cs_no[k]` low and all other lines high. Any value at or above NUM_CS drives all lines high. At most one line is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Read data for the current address, valid in the strobe cycle |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |
| cs_no | output | NUM_CS | Device selects, active low |

## Verification
The hardest case to reach is a second write to the data register in the middle of an exchange. From the outside that write looks just like a legal start. The stimulus issues it partway through a running exchange. The bench then checks that the bits a modelled device captured still form the first byte, and that busy still lasts exactly 16·2^n cycles. A second hard case is the ownership flag: probing it changes it. The stimulus therefore alternates status reads with reads and writes of neighbouring addresses, and checks after each one whether the flag moved. Random exchanges cover all four clock modes and several divider codes against a behavioural device model.

// File: rtl/spi_byte_host_pkg.sv
package spi_byte_host_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CLKID = 5'h03;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 5'h0C;
  localparam logic [ADDR_W-1:0] ADDR_CSEL  = 5'h10;

  localparam logic [BYTE_W-1:0] CSEL_NONE = 8'hFF;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [3:0] div;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{cpol: 1'b0, cpha: 1'b0, div: 4'hF};
endpackage

// File: rtl/spi_byte_host_regs.sv
module spi_byte_host_regs
  import spi_byte_host_pkg::*;
#(
  parameter logic [3:0] CLK_CODE = 4'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rx_i,
  output ctrl_t             ctrl_o,
  output logic              start_o,
  output logic [BYTE_W-1:0] tx_o,
  output logic [BYTE_W-1:0] csel_o,
  output logic              sem_o
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] csel_q;
  logic              sem_q;

  logic hit_ctrl_w, hit_stat_w, hit_stat_r, hit_data_w, hit_csel_w;

  assign hit_ctrl_w = wr_i && (addr_i == ADDR_CTRL);
  assign hit_stat_w = wr_i && (addr_i == ADDR_STAT);
  assign hit_stat_r = rd_i && (addr_i == ADDR_STAT);
  assign hit_data_w = wr_i && (addr_i == ADDR_DATA);
  assign hit_csel_w = wr_i && (addr_i == ADDR_CSEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      csel_q <= CSEL_NONE;
    end else begin
      if (hit_ctrl_w) ctrl_q <= ctrl_t'(wdata_i[5:0]);
      if (hit_csel_w) csel_q <= wdata_i;
    end
  end

  // ownership flag: release by write, acquire by read (read wins)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sem_q <= 1'b0;
    end else if (hit_stat_r) begin
      sem_q <= 1'b1;
    end else if (hit_stat_w && wdata_i[0]) begin
      sem_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CLKID: rdata_o = {4'h0, CLK_CODE};
      ADDR_CTRL:  rdata_o = {2'b00, ctrl_q};
      ADDR_STAT:  rdata_o = {6'b0, busy_i, sem_q};
      ADDR_DATA:  rdata_o = rx_i;
      ADDR_CSEL:  rdata_o = csel_q;
      default:    rdata_o = '0;
    endcase
  end

  assign start_o = hit_data_w && !busy_i;
  assign tx_o    = wdata_i;
  assign ctrl_o  = ctrl_q;
  assign csel_o  = csel_q;
  assign sem_o   = sem_q;
endmodule

// File: rtl/spi_byte_host_clkdiv.sv
module spi_byte_host_clkdiv #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // 2^code - 1; code = CNT_W wraps to all ones
  assign lim    = (CNT_W'(1) << code_i) - CNT_W'(1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_byte_host_shifter.sv
module spi_byte_host_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              cpha_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              phase_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o
);
  localparam int unsigned EDGES  = 2 * WORD_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);

  logic              busy_q, phase_q;
  logic [EDGE_W-1:0] edge_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, rx_q;
  logic              leading, do_sample, do_shift, last_edge;
  logic [WORD_W-1:0] rx_next;

  assign leading   = !edge_q[0];
  assign do_sample = cpha_i ? !leading : leading;
  assign do_shift  = cpha_i ? (leading && (edge_q != '0)) : !leading;
  assign last_edge = (edge_q == EDGE_W'(EDGES - 1));
  assign rx_next   = {rx_sh_q[WORD_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      edge_q  <= '0;
      tx_sh_q <= tx_i;
      rx_sh_q <= '0;
    end else if (busy_q && tick_i) begin
      phase_q <= !phase_q;
      edge_q  <= edge_q + EDGE_W'(1);
      if (do_sample) rx_sh_q <= rx_next;
      if (do_shift)  tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
      if (last_edge) begin
        busy_q <= 1'b0;
        rx_q   <= cpha_i ? rx_next : rx_sh_q;
      end
    end
  end

  assign busy_o  = busy_q;
  assign phase_o = phase_q;
  assign mosi_o  = tx_sh_q[WORD_W-1];
  assign rx_o    = rx_q;
endmodule

// File: rtl/spi_byte_host.sv
module spi_byte_host
  import spi_byte_host_pkg::*;
#(
  parameter int unsigned NUM_CS   = 8,
  parameter logic [3:0]  CLK_CODE = 4'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);
  ctrl_t             ctrl_w;
  logic              busy_w, start_w, tick_w, phase_w, sem_w, cpol_w;
  logic [BYTE_W-1:0] tx_w, rx_w, csel_w;

  spi_byte_host_regs #(.CLK_CODE(CLK_CODE)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rd_i    (rd_i),
    .rdata_o (rdata_o),
    .busy_i  (busy_w),
    .rx_i    (rx_w),
    .ctrl_o  (ctrl_w),
    .start_o (start_w),
    .tx_o    (tx_w),
    .csel_o  (csel_w),
    .sem_o   (sem_w)
  );

  spi_byte_host_clkdiv #(.CODE_W(4)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_w),
    .code_i (ctrl_w.div),
    .tick_o (tick_w)
  );

  spi_byte_host_shifter #(.WORD_W(BYTE_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .tx_i    (tx_w),
    .tick_i  (tick_w),
    .cpha_i  (ctrl_w.cpha),
    .miso_i  (miso_i),
    .busy_o  (busy_w),
    .phase_o (phase_w),
    .mosi_o  (mosi_o),
    .rx_o    (rx_w)
  );

  assign cpol_w = ctrl_w.cpol;
  assign sck_o  = phase_w ^ cpol_w;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_no[i] = (csel_w != BYTE_W'(i));
  end
endmodule

// File: rtl/spi_byte_host_chk.sv
module spi_byte_host_chk #(
  parameter int unsigned NUM_CS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        wdata_i,
  input logic              sck_o,
  input logic [NUM_CS-1:0] cs_no,
  input logic              busy,
  input logic              cpol,
  input logic              sem
);
  logic stat_rd, stat_wr, data_wr;
  assign stat_rd = rd_i && (addr_i == 5'h08);
  assign stat_wr = wr_i && (addr_i == 5'h08);
  assign data_wr = wr_i && (addr_i == 5'h0C);

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sck_o == cpol); // R3
  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && data_wr) |=> busy); // R4
  AST_BUSY_WRITE_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && data_wr) |=> $stable(sck_o) || busy); // R7
  AST_SEM_ACQUIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> sem); // R8
  AST_SEM_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !stat_rd && wdata_i[0]) |=> !sem); // R8
  AST_SEM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_rd && !stat_wr) |=> $stable(sem)); // R9
  AST_CS_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1); // R10
endmodule

bind spi_byte_host spi_byte_host_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .wdata_i (wdata_i),
  .sck_o   (sck_o),
  .cs_no   (cs_no),
  .busy    (busy_w),
  .cpol    (cpol_w),
  .sem     (sem_w)
);

// File: tb/spi_byte_host_bench.sv
`timescale 1ns/1ps
module spi_byte_host_bench;
  localparam int NCS = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [4:0]     addr = '0;
  logic           wr = 1'b0, rd = 1'b0, miso = 1'b0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rdata;
  logic           sck, mosi;
  logic [NCS-1:0] cs_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_byte_host #(.NUM_CS(NCS), .CLK_CODE(4'h4)) u_spi_byte_host (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
    .cs_no(cs_n)
  );

  // behavioural device
  bit       sl_en = 0, cur_cpol = 0, cur_cpha = 0;
  logic [7:0] sl_byte = '0, mosi_cap = '0;
  int       sl_cnt = 0, sck_edges = 0;

  always @(sck) begin
    if (sl_en) begin
      sck_edges++;
      if (sck != cur_cpol) begin // leading
        if (!cur_cpha) mosi_cap = {mosi_cap[6:0], mosi};
        else begin
          if (sl_cnt < 8) miso = sl_byte[7-sl_cnt];
          sl_cnt++;
        end
      end else begin // trailing
        if (!cur_cpha) begin
          sl_cnt++;
          if (sl_cnt < 8) miso = sl_byte[7-sl_cnt];
        end else mosi_cap = {mosi_cap[6:0], mosi};
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [NCS-1:0] exp_cs(int k);
    logic [NCS-1:0] v = '1;
    if (k < NCS) v[k] = 1'b0;
    return v;
  endfunction

  function automatic int exp_busy(int n);
    return 16 << n;
  endfunction

  // tasks start and end at a falling edge
  task automatic bus_wr(logic [4:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic xfer(bit cpol, bit cpha, int n, logic [7:0] tx, logic [7:0] sl,
                      bit inject, logic [7:0] tx2);
    logic [7:0] v;
    int busy_cnt = 0;
    bus_wr(5'h04, {2'b00, cpol, cpha, 4'(n)});
    cur_cpol = cpol; cur_cpha = cpha;
    check(sck == cpol, "R3 idle sck", sck, cpol);
    sl_byte = sl; sl_cnt = 0; sck_edges = 0; mosi_cap = '0;
    miso = cpha ? 1'b0 : sl[7];
    sl_en = 1;
    bus_wr(5'h0C, tx);
    for (int m = 1; m < 40000; m++) begin
      if (inject && m == 3) begin
        bus_wr(5'h0C, tx2);
        busy_cnt++;
        continue;
      end
      bus_rd(5'h08, v);
      if (!v[1]) break;
      busy_cnt++;
    end
    sl_en = 0;
    check(busy_cnt == exp_busy(n), inject ? "R7 busy length" : "R4 busy length",
          busy_cnt, exp_busy(n));
    check(sck_edges == 16, "R4 sck edges", sck_edges, 16);
    check(sck == cpol, "R4 sck back idle", sck, cpol);
    check(mosi_cap == tx, inject ? "R7 mosi kept" : "R5 mosi byte", mosi_cap, tx);
    bus_rd(5'h0C, v);
    check(v == sl, "R6 rx byte", v, sl);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cs_n == '1, "R1 cs lines", cs_n, 8'hFF);
    check(sck == 1'b0, "R1 sck", sck, 0);
    bus_rd(5'h04, v); check(v == 8'h0F, "R1 ctrl reset", v, 8'h0F);
    bus_rd(5'h10, v); check(v == 8'hFF, "R1 csel reset", v, 8'hFF);
    bus_rd(5'h08, v); check(v == 8'h00, "R1 status reset", v, 0);
    bus_wr(5'h08, 8'h01);

    // R2 clock id
    bus_rd(5'h03, v); check(v == 8'h04, "R2 clk code", v, 8'h04);
    bus_wr(5'h03, 8'hAB);
    bus_rd(5'h03, v); check(v == 8'h04, "R2 clk code after write", v, 8'h04);

    // R3 control readback and idle level
    bus_wr(5'h04, 8'hFF);
    bus_rd(5'h04, v); check(v == 8'h3F, "R3 ctrl readback", v, 8'h3F);
    check(sck == 1'b1, "R3 idle sck cpol=1", sck, 1);
    bus_wr(5'h04, 8'h12);
    bus_rd(5'h04, v); check(v == 8'h12, "R3 ctrl readback 2", v, 8'h12);
    check(sck == 1'b0, "R3 idle sck cpol=0", sck, 0);

    // R8 / R9 semaphore
    bus_rd(5'h08, v); check(v[0] == 1'b0, "R8 first read free", v[0], 0);
    bus_rd(5'h08, v); check(v[0] == 1'b1, "R8 second read owned", v[0], 1);
    bus_wr(5'h08, 8'hFE);
    bus_rd(5'h08, v); check(v[0] == 1'b1, "R8 write 0 keeps", v[0], 1);
    bus_wr(5'h08, 8'h01);
    bus_rd(5'h0C, v); bus_rd(5'h04, v); bus_rd(5'h09, v);
    bus_wr(5'h10, 8'hFF); bus_wr(5'h09, 8'h01);
    bus_rd(5'h08, v); check(v[0] == 1'b0, "R9 other cycles no acquire", v[0], 0);
    bus_wr(5'h0C, 8'h00); // harmless start at code 2 while idle
    bus_rd(5'h08, v); check(v[0] == 1'b1, "R9 data write no release", v[0], 1);
    repeat (80) @(negedge clk);
    bus_wr(5'h08, 8'h01);

    // R10 chip selects
    for (int k = 0; k < NCS; k++) begin
      bus_wr(5'h10, 8'(k));
      #1 check(cs_n == exp_cs(k), "R10 select line", cs_n, exp_cs(k));
      @(negedge clk);
    end
    bus_wr(5'h10, 8'd8);
    #1 check(cs_n == '1, "R10 out of range", cs_n, 8'hFF);
    @(negedge clk);
    bus_wr(5'h10, 8'hC3);
    bus_rd(5'h10, v); check(v == 8'hC3, "R10 readback", v, 8'hC3);
    bus_wr(5'h10, 8'hFF);
    #1 check(cs_n == '1, "R10 none", cs_n, 8'hFF);
    @(negedge clk);

    // R4-R6 directed, all modes
    xfer(0, 0, 0, 8'hA5, 8'h3C, 0, 8'h00);
    xfer(0, 1, 1, 8'h81, 8'h7E, 0, 8'h00);
    xfer(1, 0, 2, 8'h01, 8'h80, 0, 8'h00);
    xfer(1, 1, 0, 8'hFF, 8'h00, 0, 8'h00);
    // R7 write during busy
    xfer(0, 0, 2, 8'h5A, 8'hC6, 1, 8'hFF);
    xfer(1, 1, 1, 8'h96, 8'h69, 1, 8'h00);

    // random exchanges
    for (int i = 0; i < 24; i++) begin
      xfer(1'($urandom), 1'($urandom), int'($urandom % 4),
           8'($urandom), 8'($urandom), 0, 8'h00);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule